// File: doc/BRIEF.md
# ECP Reverse-Direction Receiver with Run-Length Expansion

This block is the host side of a byte-wide parallel link running in extended-capability mode, for the direction in which the peripheral sends bytes to the host. A request arrives as a start pulse with a byte count. If the link is still set up for host-to-peripheral traffic, the block first turns the bus around. It then takes strobed bytes from the peripheral and delivers them to a valid/ready byte stream until the count is reached or the peripheral stays silent too long.

A type line sampled at each peripheral strobe tells data bytes from command bytes. Command bytes that name a channel are dropped. Command bytes that carry a run length arm the receiver. The next data byte is delivered once and then repeated that many more times. Repeats that do not fit in the current request stay pending and are emitted first in the next request, with no bus handshake. All timing limits count pulses of an external tick input. The peripheral's strobe, type and ready lines pass through a reset-to-idle synchronizer.

The block uses these link lines. Toward the peripheral it drives an acknowledge line, `host_ack_o`, which is high in the idle forward state and high while a byte is acknowledged. It also drives an active-low reverse-request line, `rev_req_no`, and a bus-direction control. From the peripheral it reads the data bus, an active-low strobe, a type flag and an active-low ready line.

Top module: `ecp_rev_rx`

## Requirements
- R1: After reset the direction is forward (`dir_rev_o`=0), `host_ack_o`=1, `rev_req_no`=1, and `out_valid_o` and `done_o` are 0.
- R2: A start in the forward direction sets `dir_rev_o`=1 and `host_ack_o`=0 in the next cycle. After SETUP_TICKS ticks, `rev_req_no` goes low. `rev_req_no` is low only while `dir_rev_o`=1.
- R3: Turnaround completes when the synchronized `per_rdy_ni` is seen low within RESP_TICKS ticks. Otherwise the request ends with `done_o`=1, `timeout_o`=1 and `xfer_cnt_o`=0, and the direction stays reverse.
- R4: A start while already in reverse skips turnaround and does not wait on `per_rdy_ni`.
- R5: For each byte, the block waits up to IDLE_TICKS ticks for `per_strobe_ni` low. If the wait expires, the request ends with `done_o`=1 and `timeout_o`=0.
- R6: A byte strobed with `per_flag_i`=1 is a data byte. Its bus value is delivered once on the stream, bit 7 included.
- R7: A byte strobed with `per_flag_i`=0 and bit 7 set is a channel command. It is discarded and nothing appears on the stream.
- R8: A byte strobed with `per_flag_i`=0 and bit 7 clear carries a run length N in bits 6:0. The next data byte is delivered once and then N more times. An intervening channel command does not disarm it.
- R9: Repeats are limited by the remaining request count. Leftover repeats are kept across requests and emitted before any new bus handshake, so `host_ack_o` stays low while they drain.
- R10: Every strobe is acknowledged. A data byte is delivered first. Then `host_ack_o` goes high until the synchronized strobe is seen high again, and then goes low. If the strobe is not seen high within RESP_TICKS ticks, `host_ack_o` goes low and the request ends with `timeout_o`=1.
- R11: While `out_valid_o`=1 and `out_ready_i`=0, `out_valid_o` stays high and `out_data_o` holds its value.
- R12: `term_i` is honoured only between requests. It returns the port to forward (`dir_rev_o`=0, `rev_req_no`=1, `host_ack_o`=1) and clears all pending run-length state. While a request is active it is ignored.
- R13: `done_o` is a one-cycle pulse with `out_valid_o`=0. At that point `xfer_cnt_o` equals the number of bytes delivered in the request. The request ends with `timeout_o`=0 as soon as that number reaches `req_len_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse for all timing limits |
| start_i | input | 1 | Start a receive request (accepted between requests) |
| req_len_i | input | LEN_W | Bytes requested, sampled with start_i |
| term_i | input | 1 | Return to forward direction and clear run state |
| per_data_i | input | 8 | Peripheral data bus |
| per_strobe_ni | input | 1 | Peripheral byte strobe, active low |
| per_flag_i | input | 1 | Byte type at strobe: 1 data, 0 command |
| per_rdy_ni | input | 1 | Peripheral ready for reverse, active low |
| host_ack_o | output | 1 | Host acknowledge line |
| rev_req_no | output | 1 | Reverse request, active low |
| dir_rev_o | output | 1 | Data bus direction: 1 peripheral drives |
| out_valid_o | output | 1 | Stream byte valid |
| out_data_o | output | 8 | Stream byte |
| out_ready_i | input | 1 | Stream consumer ready |
| done_o | output | 1 | Request finished (one-cycle pulse) |
| timeout_o | output | 1 | With done_o: request ended on a handshake timeout |
| xfer_cnt_o | output | LEN_W | Bytes delivered in the current or last request |

## Verification
A corrupted run-length counter or a stale armed flag shows up in the stream as a wrong number of copies of a byte, within a few cycles after the following data strobe is acknowledged. It also shows up as `xfer_cnt_o` disagreeing with the request at the next `done_o`. Run-length state that wrongly survives a termination, or wrongly fails to carry into the next request, surfaces in the first bytes of that next request. A handshake fault shows on `host_ack_o` within the response window. Such faults show as a `timeout_o` pulse, or as `host_ack_o` rising during a request that should only drain repeats.

// File: rtl/ecp_rev_pkg.sv
package ecp_rev_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned RUN_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN_SETUP,
    ST_TURN_WAIT,
    ST_CHECK,
    ST_EMIT,
    ST_WAIT_STB,
    ST_DELIVER,
    ST_ACK
  } rx_state_e;

  typedef struct packed {
    logic             is_data;
    logic             is_run;
    logic [RUN_W-1:0] run_len;
  } byte_class_t;
endpackage

// File: rtl/ecp_pin_sync.sv
module ecp_pin_sync #(
  parameter int unsigned     W       = 3,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= RST_VAL;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ecp_tick_timer.sv
module ecp_tick_timer #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;

  assign cnt_nxt   = {1'b0, cnt_q} + 1'b1;
  assign expired_o = tick_i && (cnt_nxt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (tick_i && (cnt_q != '1))  cnt_q <= cnt_nxt[CNT_W-1:0];
endmodule

// File: rtl/ecp_byte_sort.sv
module ecp_byte_sort
  import ecp_rev_pkg::*;
(
  input  logic [BYTE_W-1:0] data_i,
  input  logic              flag_i,
  output byte_class_t       cls_o
);
  always_comb begin
    cls_o.is_data = flag_i;
    cls_o.is_run  = !flag_i && !data_i[BYTE_W-1];
    cls_o.run_len = data_i[RUN_W-1:0];
  end
endmodule

// File: rtl/ecp_run_store.sv
module ecp_run_store
  import ecp_rev_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              cmd_ld_i,
  input  logic [RUN_W-1:0]  cmd_len_i,
  input  logic              data_ld_i,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              dec_i,
  output logic [RUN_W-1:0]  run_cnt_o,
  output logic              pend_o,
  output logic [BYTE_W-1:0] rep_byte_o
);
  logic [RUN_W-1:0]  run_q;
  logic              pend_q;
  logic [BYTE_W-1:0] rep_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      run_q  <= '0;
      pend_q <= 1'b0;
      rep_q  <= '0;
    end else if (clr_i) begin
      run_q  <= '0;
      pend_q <= 1'b0;
      rep_q  <= '0;
    end else begin
      if (cmd_ld_i) begin
        run_q  <= cmd_len_i;
        pend_q <= 1'b1;
      end else if (data_ld_i && pend_q) begin
        rep_q  <= data_i;
        pend_q <= 1'b0;
      end
      if (dec_i && (run_q != '0)) run_q <= run_q - 1'b1;
    end

  assign run_cnt_o  = run_q;
  assign pend_o     = pend_q;
  assign rep_byte_o = rep_q;
endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
  import ecp_rev_pkg::*;
#(
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned SETUP_TICKS = 1,
  parameter int unsigned RESP_TICKS  = 6,
  parameter int unsigned IDLE_TICKS  = 2000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              term_i,
  input  logic [7:0]        per_data_i,
  input  logic              per_strobe_ni,
  input  logic              per_flag_i,
  input  logic              per_rdy_ni,
  output logic              host_ack_o,
  output logic              rev_req_no,
  output logic              dir_rev_o,
  output logic              out_valid_o,
  output logic [7:0]        out_data_o,
  input  logic              out_ready_i,
  output logic              done_o,
  output logic              timeout_o,
  output logic [LEN_W-1:0]  xfer_cnt_o
);
  localparam int unsigned MAX_A = (SETUP_TICKS > RESP_TICKS) ? SETUP_TICKS : RESP_TICKS;
  localparam int unsigned MAX_T = (MAX_A > IDLE_TICKS) ? MAX_A : IDLE_TICKS;
  localparam int unsigned TMR_W = $clog2(MAX_T + 1);

  // synchronized peripheral lines: {strobe_n, flag, rdy_n}
  logic [2:0] pins_s;
  logic       stb_ns, flag_s, rdy_ns;

  ecp_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b101)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({per_strobe_ni, per_flag_i, per_rdy_ni}),
    .q_o (pins_s)
  );
  assign {stb_ns, flag_s, rdy_ns} = pins_s;

  rx_state_e state_q, state_d;
  logic              dir_q, ack_q, rev_req_nq, done_q, tmo_q;
  logic [LEN_W-1:0]  remain_q, xfer_q;
  logic [BYTE_W-1:0] cap_q;

  logic              finish, fin_tmo, take, cap_en, raise_af, lower_af;
  logic              turn_start, init_low, term_fwd, load_req;
  logic              tmr_exp;
  logic [TMR_W-1:0]  tmr_limit;
  byte_class_t       cls;
  logic [RUN_W-1:0]  run_cnt;
  logic              run_pend;
  logic [BYTE_W-1:0] rep_byte;

  ecp_byte_sort u_sort (
    .data_i (per_data_i),
    .flag_i (flag_s),
    .cls_o  (cls)
  );

  ecp_run_store u_run (
    .clk_i, .rst_ni,
    .clr_i      (term_fwd),
    .cmd_ld_i   (cap_en && cls.is_run),
    .cmd_len_i  (cls.run_len),
    .data_ld_i  (cap_en && cls.is_data),
    .data_i     (per_data_i),
    .dec_i      (take && (state_q == ST_EMIT)),
    .run_cnt_o  (run_cnt),
    .pend_o     (run_pend),
    .rep_byte_o (rep_byte)
  );

  always_comb begin
    unique case (state_q)
      ST_TURN_SETUP: tmr_limit = TMR_W'(SETUP_TICKS);
      ST_WAIT_STB:   tmr_limit = TMR_W'(IDLE_TICKS);
      default:       tmr_limit = TMR_W'(RESP_TICKS);
    endcase
  end

  ecp_tick_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk_i, .rst_ni,
    .clr_i     (state_d != state_q),
    .tick_i    (tick_i),
    .limit_i   (tmr_limit),
    .expired_o (tmr_exp)
  );

  always_comb begin
    state_d    = state_q;
    finish     = 1'b0;
    fin_tmo    = 1'b0;
    take       = 1'b0;
    cap_en     = 1'b0;
    raise_af   = 1'b0;
    lower_af   = 1'b0;
    turn_start = 1'b0;
    init_low   = 1'b0;
    term_fwd   = 1'b0;
    load_req   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (term_i) term_fwd = 1'b1;
        else if (start_i) begin
          load_req = 1'b1;
          if (dir_q) state_d = ST_CHECK;
          else begin
            turn_start = 1'b1;
            state_d    = ST_TURN_SETUP;
          end
        end
      end
      ST_TURN_SETUP: begin
        if (tmr_exp) begin
          init_low = 1'b1;
          state_d  = ST_TURN_WAIT;
        end
      end
      ST_TURN_WAIT: begin
        if (!rdy_ns) state_d = ST_CHECK;
        else if (tmr_exp) begin
          finish  = 1'b1;
          fin_tmo = 1'b1;
        end
      end
      ST_CHECK: begin
        if (remain_q == '0) finish = 1'b1;
        else if ((run_cnt != '0) && !run_pend) state_d = ST_EMIT;
        else state_d = ST_WAIT_STB;
      end
      ST_EMIT: begin
        if (out_ready_i) begin
          take    = 1'b1;
          state_d = ((remain_q > LEN_W'(1)) && (run_cnt > RUN_W'(1))) ? ST_EMIT : ST_CHECK;
        end
      end
      ST_WAIT_STB: begin
        if (!stb_ns) begin
          cap_en = 1'b1;
          if (cls.is_data) state_d = ST_DELIVER;
          else begin
            raise_af = 1'b1;
            state_d  = ST_ACK;
          end
        end else if (tmr_exp) finish = 1'b1;
      end
      ST_DELIVER: begin
        if (out_ready_i) begin
          take     = 1'b1;
          raise_af = 1'b1;
          state_d  = ST_ACK;
        end
      end
      ST_ACK: begin
        if (stb_ns) begin
          lower_af = 1'b1;
          state_d  = ST_CHECK;
        end else if (tmr_exp) begin
          lower_af = 1'b1;
          finish   = 1'b1;
          fin_tmo  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (finish) state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      dir_q      <= 1'b0;
      ack_q      <= 1'b1;
      rev_req_nq <= 1'b1;
      remain_q   <= '0;
      xfer_q     <= '0;
      cap_q      <= '0;
      done_q     <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
      if (finish) tmo_q <= fin_tmo;
      if (term_fwd) begin
        dir_q      <= 1'b0;
        ack_q      <= 1'b1;
        rev_req_nq <= 1'b1;
      end
      if (load_req) begin
        remain_q <= req_len_i;
        xfer_q   <= '0;
      end
      if (turn_start) begin
        dir_q <= 1'b1;
        ack_q <= 1'b0;
      end
      if (init_low) rev_req_nq <= 1'b0;
      if (cap_en && cls.is_data) cap_q <= per_data_i;
      if (take) begin
        remain_q <= remain_q - 1'b1;
        xfer_q   <= xfer_q + 1'b1;
      end
      if (raise_af) ack_q <= 1'b1;
      if (lower_af) ack_q <= 1'b0;
    end

  assign host_ack_o  = ack_q;
  assign rev_req_no  = rev_req_nq;
  assign dir_rev_o   = dir_q;
  assign out_valid_o = (state_q == ST_EMIT) || (state_q == ST_DELIVER);
  assign out_data_o  = (state_q == ST_EMIT) ? rep_byte : cap_q;
  assign done_o      = done_q;
  assign timeout_o   = tmo_q;
  assign xfer_cnt_o  = xfer_q;
endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk #(
  parameter int unsigned LEN_W = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       term_i,
  input logic       host_ack_o,
  input logic       rev_req_no,
  input logic       dir_rev_o,
  input logic       out_valid_o,
  input logic [7:0] out_data_o,
  input logic       out_ready_i,
  input logic       done_o
);
  a_r11_valid_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  a_r2_init_only_rev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rev_req_no |-> dir_rev_o);

  a_r12_fwd_on_term: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dir_rev_o) |-> $past(term_i));

  a_r10_ack_low_on_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !host_ack_o);

  a_r13_done_no_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !out_valid_o);

  a_r13_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind ecp_rev_rx ecp_rev_rx_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_ecp_rev_rx.sv
module sim_ecp_rev_rx;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 16;
  localparam int NVEC       = 10;
  // {flag, byte, expected copies}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'h41, 8'd1},
    {1'b0, 8'h85, 8'd0},
    {1'b1, 8'hC3, 8'd1},
    {1'b0, 8'h03, 8'd0},
    {1'b1, 8'h5A, 8'd4},
    {1'b0, 8'h00, 8'd0},
    {1'b1, 8'h99, 8'd1},
    {1'b0, 8'h02, 8'd0},
    {1'b0, 8'h81, 8'd0},
    {1'b1, 8'h0F, 8'd3}
  };

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             tick_i;
  logic             start_i;
  logic [LEN_W-1:0] req_len_i;
  logic             term_i;
  logic [7:0]       per_data_i;
  logic             per_strobe_ni;
  logic             per_flag_i;
  logic             per_rdy_ni;
  logic             host_ack_o, rev_req_no, dir_rev_o;
  logic             out_valid_o;
  logic [7:0]       out_data_o;
  logic             out_ready_i = 1'b1;
  logic             done_o, timeout_o;
  logic [LEN_W-1:0] xfer_cnt_o;

  int n_chk = 0, n_fail = 0, cyc = 0, rdy_cnt = 0, rx_n = 0;
  logic [7:0] rx_q [256];
  bit ack_seen = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ecp_rev_rx #(.LEN_W(LEN_W), .IDLE_TICKS(80)) u0 (.*);

  always @(negedge clk_i) begin
    rdy_cnt++;
    out_ready_i = (rdy_cnt % 3) != 2;
    if (out_valid_o && out_ready_i && rx_n < 256) begin
      rx_q[rx_n] = out_data_o;
      rx_n++;
    end
    if (host_ack_o) ack_seen = 1;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic start_req(input int len);
    @(negedge clk_i);
    req_len_i = LEN_W'(len);
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic pulse_term();
    @(negedge clk_i);
    term_i = 1;
    @(negedge clk_i);
    term_i = 0;
  endtask

  task automatic wait_done(output int cnt, output int tmo);
    int k;
    for (k = 0; k < 3000 && !done_o; k++) @(negedge clk_i);
    chk("R13", "done seen", int'(done_o), 1);
    cnt = int'(xfer_cnt_o);
    tmo = int'(timeout_o);
    @(negedge clk_i);
  endtask

  task automatic strobe(input bit flag, input logic [7:0] b);
    int k;
    @(negedge clk_i);
    per_data_i = b;
    per_flag_i = flag;
    @(negedge clk_i);
    per_strobe_ni = 0;
    for (k = 0; k < 60 && !host_ack_o; k++) @(negedge clk_i);
    chk("R10", "ack rise", int'(host_ack_o), 1);
    per_strobe_ni = 1;
    for (k = 0; k < 20 && host_ack_o; k++) @(negedge clk_i);
    chk("R10", "ack fall", int'(host_ack_o), 0);
  endtask

  initial begin
    int cnt, tmo, base, k;
    rst_ni = 0; tick_i = 1; start_i = 0; req_len_i = '0; term_i = 0;
    per_data_i = '0; per_strobe_ni = 1; per_flag_i = 0; per_rdy_ni = 1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", "dir", int'(dir_rev_o), 0);
    chk("R1", "host_ack", int'(host_ack_o), 1);
    chk("R1", "rev_req_n", int'(rev_req_no), 1);
    chk("R1", "valid", int'(out_valid_o), 0);
    chk("R1", "done", int'(done_o), 0);

    // turnaround timeout: ready line never answers
    start_req(4);
    wait_done(cnt, tmo);
    chk("R3", "timeout", tmo, 1);
    chk("R3", "count", cnt, 0);
    chk("R3", "dir stays rev", int'(dir_rev_o), 1);
    pulse_term();
    chk("R12", "dir fwd", int'(dir_rev_o), 0);
    chk("R12", "rev_req_n high", int'(rev_req_no), 1);
    chk("R12", "host_ack high", int'(host_ack_o), 1);

    // main table-driven request
    @(negedge clk_i);
    req_len_i = LEN_W'(200);
    start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    chk("R2", "dir rev", int'(dir_rev_o), 1);
    chk("R2", "host_ack low", int'(host_ack_o), 0);
    chk("R2", "rev_req_n still high", int'(rev_req_no), 1);
    for (k = 0; k < 10 && rev_req_no; k++) @(negedge clk_i);
    chk("R2", "rev_req_n low", int'(rev_req_no), 0);
    per_rdy_ni = 0;
    for (int i = 0; i < NVEC; i++) begin
      logic f;
      logic [7:0] b;
      int n;
      string tag;
      f = VEC[i][16];
      b = VEC[i][15:8];
      n = int'(VEC[i][7:0]);
      tag = f ? ((n > 1) ? "R8" : "R6") : (b[7] ? "R7" : "R8");
      base = rx_n;
      strobe(f, b);
      repeat (30) @(negedge clk_i);
      chk(tag, "copies", rx_n - base, n);
      for (int j = base; j < rx_n; j++) chk(tag, "byte", int'(rx_q[j]), int'(b));
    end
    wait_done(cnt, tmo);
    chk("R5", "idle end no timeout", tmo, 0);
    chk("R13", "count", cnt, 10);

    // reverse already: no turnaround; repeats cut by request length
    per_rdy_ni = 1;
    base = rx_n;
    start_req(3);
    strobe(0, 8'h05);
    strobe(1, 8'h77);
    wait_done(cnt, tmo);
    chk("R4", "no turnaround timeout", tmo, 0);
    chk("R9", "count limited", cnt, 3);
    chk("R9", "delivered", rx_n - base, 3);
    for (int j = base; j < rx_n; j++) chk("R8", "repeat byte", int'(rx_q[j]), 8'h77);
    ack_seen = 0;
    base = rx_n;
    start_req(2);
    wait_done(cnt, tmo);
    chk("R9", "carried count", cnt, 2);
    chk("R9", "no handshake", int'(ack_seen), 0);
    for (int j = base; j < rx_n; j++) chk("R9", "carried byte", int'(rx_q[j]), 8'h77);
    base = rx_n;
    start_req(4);
    repeat (10) @(negedge clk_i);
    chk("R9", "last carried", rx_n - base, 1);
    strobe(1, 8'h12);
    wait_done(cnt, tmo);
    chk("R5", "idle end", tmo, 0);
    chk("R13", "count", cnt, 2);
    chk("R6", "fresh byte", int'(rx_q[base+1]), 8'h12);

    // acknowledge timeout, term ignored while active
    start_req(5);
    @(negedge clk_i);
    per_data_i = 8'h6E;
    per_flag_i = 1;
    @(negedge clk_i);
    per_strobe_ni = 0;
    repeat (3) @(negedge clk_i);
    term_i = 1;
    @(negedge clk_i);
    term_i = 0;
    wait_done(cnt, tmo);
    chk("R10", "ack timeout", tmo, 1);
    chk("R10", "count", cnt, 1);
    chk("R10", "host_ack low", int'(host_ack_o), 0);
    chk("R12", "term ignored", int'(dir_rev_o), 1);
    per_strobe_ni = 1;
    repeat (5) @(negedge clk_i);

    // term clears armed run state
    start_req(10);
    strobe(0, 8'h04);
    wait_done(cnt, tmo);
    chk("R7", "command gives no byte", cnt, 0);
    pulse_term();
    chk("R12", "dir fwd", int'(dir_rev_o), 0);
    per_rdy_ni = 1;
    start_req(10);
    for (k = 0; k < 10 && rev_req_no; k++) @(negedge clk_i);
    per_rdy_ni = 0;
    base = rx_n;
    strobe(1, 8'h33);
    wait_done(cnt, tmo);
    chk("R12", "run cleared count", cnt, 1);
    chk("R12", "run cleared bytes", rx_n - base, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule